// File: doc/BRIEF.md
# Outstanding Load Interlock Scoreboard

This block sits next to the issue stage of a single-issue, in-order pipeline. It remembers the destination register of every load that has gone out to memory and whose data has not yet come back. Each cycle it looks at the instruction waiting to issue and decides whether that instruction may go. The answer comes back to the issue stage on a single stall line.

An instruction is held back for one of two reasons. The first is that it is a load and the load tracking queue already holds its maximum number of entries. The second is that one of its enabled source registers is the destination of a load that is still pending. Memory latency is not fixed. The memory side therefore reports each returning load with a one-cycle completion strobe. Loads always return in the order they were issued, so each strobe retires the oldest pending entry.

Top module: `load_hazard_sb`

## Requirements
- R1: While reset is high and in the cycle after reset is released, the queue is empty and stall is low for any request whose sources are enabled.
- R2: When no request is presented (`req_valid` low), stall is low.
- R3: A request issues (stall low) when fewer than `QDEPTH` (default 4) loads are pending and no enabled source matches a pending destination. An issued load (`req_is_load` high) enters the queue.
- R4: A load request with `QDEPTH` loads pending and no completion strobe in the same cycle is stalled.
- R5: A load request with `QDEPTH` loads pending and `mem_done` high in the same cycle is not stalled for occupancy. The oldest entry retires and the new one enters in that cycle.
- R6: A request whose enabled source tag (`req_rs1`/`req_rs2` with its enable high) equals the destination tag of any pending load is stalled. A source with its enable low is never compared.
- R7: A dependency is still stalled in the cycle in which the matching load completes. It issues in the following cycle, unless another pending load has the same destination.
- R8: Each `mem_done` strobe retires the oldest pending load and no other.
- R9: `mem_done` with no load pending has no effect on the queue.
- R10: A load request that is stalled is not recorded in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An instruction is waiting to issue |
| req_rs1 | input | TAG_W | First source register number |
| req_rs1_en | input | 1 | First source field is used |
| req_rs2 | input | TAG_W | Second source register number |
| req_rs2_en | input | 1 | Second source field is used |
| req_is_load | input | 1 | The waiting instruction is a load |
| req_rd | input | TAG_W | Destination register of the load |
| mem_done | input | 1 | Oldest pending load has returned its data |
| stall | output | 1 | Hold the waiting instruction this cycle |

## Verification
A corrupted tag entry, or a lost or duplicated entry, shows up at the ports as a wrong stall decision. This happens the first time a later instruction reads that register, or the first time occupancy reaches the limit. That can be many cycles after the fault itself. The bench therefore runs a reference queue in step with the design and compares stall on every cycle of long random runs. Random runs use varied load latencies and stray completion strobes. Occupancy errors are caught at the limit within four loads of the fault. A wrong retire order shows up as a stall on the wrong register at the next read of a still-pending destination.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_FULL = 2'd1,
    HOLD_RAW  = 2'd2
  } hold_e;
endpackage

// File: rtl/sb_tag_fifo.sv
module sb_tag_fifo #(
  parameter int QDEPTH = 4,
  parameter int TAG_W  = 4,
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic [TAG_W-1:0]        push_tag,
  input  logic                    pop,
  output logic [QDEPTH*TAG_W-1:0] tags_flat,
  output logic [QDEPTH-1:0]       live,
  output logic [CNT_W-1:0]        occ,
  output logic                    full
);
  logic [TAG_W-1:0] tag_mem [QDEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_eff;

  assign pop_eff = pop && (occ != '0);
  assign full    = (occ == CNT_W'(QDEPTH));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Tag storage carries no reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (push) tag_mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      live   <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop_eff) rd_ptr <= nxt(rd_ptr);
      case ({push, pop_eff})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      for (int i = 0; i < QDEPTH; i++) begin
        if (push && (wr_ptr == PTR_W'(i)))
          live[i] <= 1'b1;
        else if (pop_eff && (rd_ptr == PTR_W'(i)))
          live[i] <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < QDEPTH; g++) begin : g_out
      assign tags_flat[g*TAG_W +: TAG_W] = tag_mem[g];
    end
  endgenerate
endmodule

// File: rtl/sb_raw_match.sv
module sb_raw_match #(
  parameter int QDEPTH = 4,
  parameter int TAG_W  = 4
) (
  input  logic [QDEPTH*TAG_W-1:0] tags_flat,
  input  logic [QDEPTH-1:0]       live,
  input  logic [TAG_W-1:0]        src,
  input  logic                    src_en,
  output logic                    hit
);
  logic [QDEPTH-1:0] eq;
  generate
    for (genvar g = 0; g < QDEPTH; g++) begin : g_cmp
      assign eq[g] = live[g] && (tags_flat[g*TAG_W +: TAG_W] == src);
    end
  endgenerate
  assign hit = src_en && (|eq);
endmodule

// File: rtl/load_hazard_sb.sv
module load_hazard_sb #(
  parameter int NUM_REGS = 16,
  parameter int QDEPTH   = 4,
  localparam int TAG_W   = $clog2(NUM_REGS),
  localparam int CNT_W   = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_rs1,
  input  logic             req_rs1_en,
  input  logic [TAG_W-1:0] req_rs2,
  input  logic             req_rs2_en,
  input  logic             req_is_load,
  input  logic [TAG_W-1:0] req_rd,
  input  logic             mem_done,
  output logic             stall
);
  import sb_pkg::*;

  logic [QDEPTH*TAG_W-1:0] tags_flat;
  logic [QDEPTH-1:0]       live;
  logic [CNT_W-1:0]        occ;
  logic                    full;
  logic                    hit1, hit2;
  logic                    push;
  hold_e                   hold;

  sb_tag_fifo #(.QDEPTH(QDEPTH), .TAG_W(TAG_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_tag(req_rd), .pop(mem_done),
    .tags_flat(tags_flat), .live(live), .occ(occ), .full(full)
  );

  sb_raw_match #(.QDEPTH(QDEPTH), .TAG_W(TAG_W)) u_m1 (
    .tags_flat(tags_flat), .live(live), .src(req_rs1), .src_en(req_rs1_en), .hit(hit1)
  );

  sb_raw_match #(.QDEPTH(QDEPTH), .TAG_W(TAG_W)) u_m2 (
    .tags_flat(tags_flat), .live(live), .src(req_rs2), .src_en(req_rs2_en), .hit(hit2)
  );

  // Dependencies look only at registered state: a returning load unblocks
  // its reader one cycle later. Occupancy may use the same-cycle retire.
  always_comb begin
    hold = HOLD_NONE;
    if (req_valid) begin
      if (hit1 || hit2)
        hold = HOLD_RAW;
      else if (req_is_load && full && !mem_done)
        hold = HOLD_FULL;
    end
  end

  assign stall = (hold != HOLD_NONE);
  assign push  = req_valid && req_is_load && !stall;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_is_load,
  input logic             mem_done,
  input logic             stall,
  input logic [CNT_W-1:0] occ
);
  a_r1_reset_empties: assert property (@(posedge clk) rst |=> (occ == '0));

  a_r2_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !stall);

  a_r4_full_holds_load: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_load && occ == CNT_W'(QDEPTH) && !mem_done) |-> stall);

  a_r3_load_grows_queue: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_load && !stall && !mem_done) |=> (occ == $past(occ) + 1'b1));

  a_r5_swap_keeps_occ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_load && !stall && mem_done && occ != '0) |=> (occ == $past(occ)));

  a_r9_empty_done_ignored: assert property (@(posedge clk) disable iff (rst)
    (mem_done && occ == '0 && !(req_valid && req_is_load && !stall)) |=> (occ == '0));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(QDEPTH));
endmodule

bind load_hazard_sb sb_checker #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_load(req_is_load),
  .mem_done(mem_done), .stall(stall), .occ(occ)
);

// File: tb/load_hazard_sb_bench.sv
`timescale 1ns/1ps
module load_hazard_sb_bench;
  localparam int TW = 4;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_rs1_en = 0, req_rs2_en = 0, req_is_load = 0, mem_done = 0;
  logic [TW-1:0] req_rs1 = 0, req_rs2 = 0, req_rd = 0;
  logic stall;
  int vectors = 0, errors = 0;
  int q[$];

  always #4 clk = ~clk;

  load_hazard_sb u_load_hazard_sb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rs1(req_rs1),
    .req_rs1_en(req_rs1_en), .req_rs2(req_rs2), .req_rs2_en(req_rs2_en),
    .req_is_load(req_is_load), .req_rd(req_rd), .mem_done(mem_done), .stall(stall)
  );

  function automatic bit pending(int t);
    foreach (q[i]) if (q[i] == t) return 1;
    return 0;
  endfunction

  task automatic step(input bit v, input int a, input bit ae, input int b, input bit be,
                      input bit ld, input int d, input bit dn, input string tag,
                      input int force_exp = -1);
    bit raw, ful, exp_s;
    @(negedge clk);
    req_valid = v; req_rs1 = TW'(a); req_rs1_en = ae; req_rs2 = TW'(b);
    req_rs2_en = be; req_is_load = ld; req_rd = TW'(d); mem_done = dn;
    #1;
    raw = v && ((ae && pending(a)) || (be && pending(b)));
    ful = v && ld && (q.size() == 4) && !dn;
    exp_s = raw || ful;
    if (force_exp >= 0 && exp_s != bit'(force_exp)) begin
      errors++;
      $display("FAIL %s: bench scenario expectation %0d differs from model %0d", tag, force_exp, exp_s);
    end
    vectors++;
    if (stall !== exp_s) begin
      errors++;
      $display("FAIL %s: stall=%b expected %b", tag, stall, exp_s);
    end
    if (dn && q.size() > 0) void'(q.pop_front());
    if (v && ld && !exp_s) q.push_back(d);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (stall !== 1'b0) begin errors++; $display("FAIL R1: stall=%b expected 0 in reset", stall); end
    @(negedge clk); rst = 0;
    step(1, 3, 1, 4, 1, 0, 0, 0, "R1", 0);
    step(0, 3, 1, 4, 1, 1, 0, 0, "R2", 0);
    for (int i = 1; i <= 4; i++) step(1, 0, 0, 0, 0, 1, i, 0, "R3", 0);
    step(1, 0, 0, 0, 0, 1, 5, 0, "R4", 1);
    step(1, 5, 1, 0, 0, 0, 0, 0, "R10", 0);
    step(1, 3, 0, 7, 1, 0, 0, 0, "R6", 0);
    step(1, 2, 1, 0, 0, 0, 0, 0, "R6", 1);
    step(1, 0, 0, 0, 0, 1, 5, 1, "R5", 0);
    step(1, 1, 1, 0, 0, 0, 0, 0, "R8", 0);
    step(1, 0, 0, 2, 1, 0, 0, 0, "R8", 1);
    step(1, 2, 1, 0, 0, 0, 0, 1, "R7", 1);
    step(1, 2, 1, 0, 0, 0, 0, 0, "R7", 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9", 0);
    step(1, 0, 0, 0, 0, 1, 9, 0, "R9", 0);
    step(1, 9, 1, 0, 0, 0, 0, 0, "R9", 1);
    step(1, 9, 1, 0, 0, 0, 0, 1, "R7", 1);
    step(1, 9, 1, 0, 0, 0, 0, 0, "R7", 0);
    for (int n = 0; n < 6000; n++) begin
      bit v, ld, dn;
      int a, b, d;
      string t;
      v = ($urandom_range(0, 9) < 8);
      ld = ($urandom_range(0, 9) < 4);
      dn = ($urandom_range(0, 9) < 3);
      a = $urandom_range(0, 15); b = $urandom_range(0, 15); d = $urandom_range(0, 15);
      t = (v && ld && q.size() == 4 && !dn) ? "R4" : "R6";
      step(v, a, $urandom_range(0, 1) == 1, b, $urandom_range(0, 1) == 1, ld, d, dn, t);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule